// File: doc/BRIEF.md
# Multiplexed LCD Frame Timing Generator

This block paces the drive of a multiplexed segment display. A slow-clock enable is divided by a 3-bit programmable ratio into phase ticks. Each common phase lasts 256 of those ticks. The block walks through the configured number of commons to build a frame, and it flags both the phase boundary and the frame boundary with single-cycle pulses.

Within every phase it raises a buffer-drive enable for a selectable on-time. Some on-time codes give an absolute number of slow-clock periods. Others give a fraction of the phase.

The low-power request and the bias selection can be written at any time. The block copies them to its outputs only at a frame boundary, or continuously while it is idle. This keeps the waveform stage from seeing a change part-way through a frame.

Top module: `lcd_frame_timer`

## Requirements
- R1: With the divider field at n (0..7) and `slow_tick` high on every clock, `phase_stb` pulses for one cycle on cycle k = m*256*(n+1) - 1 after enabling, for m = 1, 2, 3 and so on. Cycle 0 is the first cycle in which `enable` is high.
- R2: `com_sel` holds the number of commons minus one. `com_idx` starts at 0, advances by one after each `phase_stb`, and returns to 0 after the phase where it equals `com_sel`.
- R3: `frame_end` is high only together with `phase_stb`, and only on the strobe of the phase whose `com_idx` equals `com_sel`.
- R4: For `buf_code` 1..7, `buf_en` is high for the first 2^`buf_code` slow ticks of each phase. The on-time is cut off at the phase end if the phase is shorter.
- R5: For `buf_code` 8, `buf_en` is high for the first half of each phase, which is 128*(n+1) slow ticks. For `buf_code` 9 it is high for the whole phase.
- R6: `buf_code` 0 and the unused codes 10..15 keep `buf_en` low.
- R7: While enabled, `lp_active` changes only in the cycle after a `frame_end` pulse, and then takes the value `lp_req` had on that pulse. While disabled, it follows `lp_req` one cycle later. After reset it is 0.
- R8: `bias_out` follows the same capture rule as `lp_active`, applied to the 2-bit `bias_sel`. The codes 0..3 stand for bias 1, 1/2, 1/3 and 1/4.
- R9: In reset, and while `enable` is low, the following all read 0: `phase_stb`, `frame_end` and `buf_en`. `com_idx` reads 0 one cycle after `enable` falls. Re-enabling starts a fresh frame from phase 0.
- R10: While `slow_tick` is low, no divided tick occurs, no `phase_stb` is produced and `com_idx` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable marking a slow-clock period |
| enable | input | 1 | Runs the timing chain when high |
| div_sel | input | 3 | Divider field n; ratio is n+1 |
| com_sel | input | COM_W | Number of commons minus one |
| buf_code | input | 4 | Buffer on-time code |
| lp_req | input | 1 | Requested low-power waveform |
| bias_sel | input | 2 | Requested bias code |
| com_idx | output | COM_W | Common currently driven |
| phase_stb | output | 1 | Last divided tick of a phase |
| frame_end | output | 1 | Last divided tick of a frame |
| buf_en | output | 1 | Buffer-drive enable |
| lp_active | output | 1 | Low-power mode for the current frame |
| bias_out | output | 2 | Bias code for the current frame |

## Verification
A prescaler or phase counter that holds a wrong value moves the first `phase_stb` to another cycle. A scoreboard that knows the exact strobe cycle of every phase catches this at the first phase boundary, at most 2048 slow ticks later.

A wrong common counter shows as a wrong `com_idx` or a misplaced `frame_end` at the next strobe. A stuck on-time counter changes the count of `buf_en` cycles in that same phase.

A frame-boundary latch that loads at the wrong moment shows up as `lp_active` or `bias_out` changing inside a frame. The scoreboard sees this at the next phase strobe.

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
  parameter int PHASE_TICKS = 256,
  parameter int COM_W       = 2,
  parameter int DIV_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [COM_W-1:0] com_sel,
  input  logic [3:0]       buf_code,
  input  logic             lp_req,
  input  logic [1:0]       bias_sel,
  output logic [COM_W-1:0] com_idx,
  output logic             phase_stb,
  output logic             frame_end,
  output logic             buf_en,
  output logic             lp_active,
  output logic [1:0]       bias_out
);
  localparam int PH_W = $clog2(PHASE_TICKS);
  localparam int SL_W = PH_W + DIV_W + 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASE_TICKS - 1);

  logic [DIV_W-1:0] pre_cnt;
  logic [PH_W-1:0]  ph_cnt;
  logic [SL_W-1:0]  sl_cnt;
  logic [SL_W-1:0]  half_len;
  logic             buf_on;

  wire div_tick = enable && slow_tick && (pre_cnt >= div_sel);
  wire com_last = (com_idx >= com_sel);
  assign phase_stb = div_tick && (ph_cnt == PH_LAST);
  assign frame_end = phase_stb && com_last;
  assign half_len  = (SL_W'(div_sel) + SL_W'(1)) << (PH_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      ph_cnt  <= '0;
      sl_cnt  <= '0;
      com_idx <= '0;
    end else if (!enable) begin
      pre_cnt <= '0;
      ph_cnt  <= '0;
      sl_cnt  <= '0;
      com_idx <= '0;
    end else begin
      if (slow_tick)
        pre_cnt <= div_tick ? '0 : pre_cnt + DIV_W'(1);
      if (div_tick)
        ph_cnt <= (ph_cnt == PH_LAST) ? '0 : ph_cnt + PH_W'(1);
      if (phase_stb)
        com_idx <= com_last ? '0 : com_idx + COM_W'(1);
      if (phase_stb)
        sl_cnt <= '0;
      else if (slow_tick && (sl_cnt != '1))
        sl_cnt <= sl_cnt + SL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_active <= 1'b0;
      bias_out  <= '0;
    end else if (!enable || frame_end) begin
      lp_active <= lp_req;
      bias_out  <= bias_sel;
    end
  end

  always_comb begin
    buf_on = 1'b0;
    if (buf_code >= 4'd1 && buf_code <= 4'd7)
      buf_on = sl_cnt < (SL_W'(1) << buf_code[2:0]);
    else if (buf_code == 4'd8)
      buf_on = sl_cnt < half_len;
    else if (buf_code == 4'd9)
      buf_on = 1'b1;
  end

  assign buf_en = enable && buf_on;
endmodule

module lcd_frame_timer_chk #(
  parameter int COM_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slow_tick,
  input logic             enable,
  input logic [COM_W-1:0] com_sel,
  input logic [3:0]       buf_code,
  input logic [COM_W-1:0] com_idx,
  input logic             phase_stb,
  input logic             frame_end,
  input logic             buf_en,
  input logic             lp_active,
  input logic [1:0]       bias_out
);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !phase_stb && !frame_end && !buf_en);
  a_r9_idle_com: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> com_idx == '0);
  a_r3_frame_in_stb: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> phase_stb);
  a_r3_frame_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> com_idx >= com_sel);
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> com_idx == '0);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    phase_stb && !frame_end |=> com_idx == $past(com_idx) + COM_W'(1));
  a_r10_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_tick |-> !phase_stb);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !slow_tick |=> $stable(com_idx));
  a_r7_lp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !frame_end |=> $stable(lp_active));
  a_r8_bias_hold: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !frame_end |=> $stable(bias_out));
  a_r6_code_off: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_code == 4'd0 || buf_code > 4'd9) |-> !buf_en);
  a_r5_full_on: assert property (@(posedge clk) disable iff (!rst_n)
    enable && buf_code == 4'd9 |-> buf_en);
endmodule

bind lcd_frame_timer lcd_frame_timer_chk #(.COM_W(COM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .enable(enable),
  .com_sel(com_sel), .buf_code(buf_code), .com_idx(com_idx),
  .phase_stb(phase_stb), .frame_end(frame_end), .buf_en(buf_en),
  .lp_active(lp_active), .bias_out(bias_out)
);

// File: tb/lcd_frame_timer_bench.sv
`timescale 1ns/1ps
module lcd_frame_timer_bench;
  logic       clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b1, enable = 1'b0;
  logic [2:0] div_sel = '0;
  logic [1:0] com_sel = '0;
  logic [3:0] buf_code = '0;
  logic       lp_req = 1'b0;
  logic [1:0] bias_sel = '0;
  logic [1:0] com_idx;
  logic       phase_stb, frame_end, buf_en, lp_active;
  logic [1:0] bias_out;

  lcd_frame_timer u_lcd_frame_timer (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .enable(enable),
    .div_sel(div_sel), .com_sel(com_sel), .buf_code(buf_code),
    .lp_req(lp_req), .bias_sel(bias_sel), .com_idx(com_idx),
    .phase_stb(phase_stb), .frame_end(frame_end), .buf_en(buf_en),
    .lp_active(lp_active), .bias_out(bias_out)
  );

  always #2 clk = ~clk;

  typedef struct {
    int         cyc;
    int         com;
    bit         fe;
    bit         lp;
    logic [1:0] bias;
    int         bon;
    string      btag;
  } item_t;

  item_t exp_q[$];
  int    n_tests = 0, n_fail = 0;
  bit    mon_on = 1'b0, done = 1'b0;
  int    cyc = 0, bcnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (!enable) begin
        cyc = 0;
        bcnt = 0;
      end else begin
        if (buf_en) bcnt++;
        if (frame_end && !phase_stb) check(0, "R3 frame_end without strobe", 1, 0);
        if (phase_stb) begin
          if (exp_q.size() == 0) begin
            check(0, "R1 unexpected phase strobe", cyc, -1);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            check(cyc == it.cyc, "R1 strobe cycle", cyc, it.cyc);
            check(int'(com_idx) == it.com, "R2 common index", int'(com_idx), it.com);
            check(frame_end == it.fe, "R3 frame end", int'(frame_end), int'(it.fe));
            check(lp_active == it.lp, "R7 low-power latch", int'(lp_active), int'(it.lp));
            check(bias_out == it.bias, "R8 bias latch", int'(bias_out), int'(it.bias));
            check(bcnt == it.bon, it.btag, bcnt, it.bon);
          end
          bcnt = 0;
        end else if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
          check(0, "R1 missing strobe", 0, cyc);
          void'(exp_q.pop_front());
        end
        cyc++;
      end
    end
  end

  task automatic run_cfg(input int d, input int ncs, input int code, input bit lp0,
                         input logic [1:0] b0, input int p_sw, input int nph,
                         input string btag);
    int L, ncom, bon, wd;
    @(posedge clk); #1;
    enable = 1'b0; div_sel = 3'(d); com_sel = 2'(ncs); buf_code = 4'(code);
    lp_req = lp0; bias_sel = b0;
    repeat (3) @(posedge clk);
    L = 256 * (d + 1);
    ncom = ncs + 1;
    if (code >= 1 && code <= 7) bon = ((1 << code) < L) ? (1 << code) : L;
    else if (code == 8) bon = L / 2;
    else if (code == 9) bon = L;
    else bon = 0;
    for (int n = 1; n <= nph; n++) begin
      item_t it;
      bit sw;
      sw = (p_sw > 0) && ((n - 1) / ncom > (p_sw - 1) / ncom);
      it.cyc = n * L - 1;
      it.com = (n - 1) % ncom;
      it.fe = ((n - 1) % ncom) == ncom - 1;
      it.lp = sw ? ~lp0 : lp0;
      it.bias = sw ? ~b0 : b0;
      it.bon = bon;
      it.btag = btag;
      exp_q.push_back(it);
    end
    #1 enable = 1'b1;
    if (p_sw > 0) begin
      repeat ((p_sw - 1) * L + L / 2) @(posedge clk);
      #1;
      lp_req = ~lp0;
      bias_sel = ~b0;
    end
    wd = 0;
    while (exp_q.size() > 0 && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    repeat (5) @(posedge clk);
    #1 enable = 1'b0;
    @(negedge clk);
    check(com_idx == 2'd0, "R9 common index cleared on disable", int'(com_idx), 0);
    check(!phase_stb && !frame_end && !buf_en, "R9 pulses quiet while disabled",
          int'({phase_stb, frame_end, buf_en}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int stb_seen;
    repeat (3) @(negedge clk);
    check(!phase_stb && !frame_end && !buf_en && com_idx == 0 && !lp_active && bias_out == 0,
          "R9 reset state",
          int'({phase_stb, frame_end, buf_en, com_idx, lp_active, bias_out}), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    lp_req = 1'b1; bias_sel = 2'd2;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(lp_active == 1'b1, "R7 idle tracking", int'(lp_active), 1);
    check(bias_out == 2'd2, "R8 idle tracking", int'(bias_out), 2);
    @(posedge clk); #1 lp_req = 1'b0; bias_sel = 2'd0;

    buf_code = 4'd3; div_sel = 3'd0; com_sel = 2'd3;
    slow_tick = 1'b0;
    @(posedge clk); #1 enable = 1'b1;
    stb_seen = 0;
    repeat (600) begin
      @(negedge clk);
      if (phase_stb) stb_seen++;
    end
    check(stb_seen == 0, "R10 no strobe without slow tick", stb_seen, 0);
    check(com_idx == 2'd0, "R10 common index holds", int'(com_idx), 0);
    @(posedge clk); #1 enable = 1'b0; slow_tick = 1'b1;

    mon_on = 1'b1;
    run_cfg(0, 3, 3, 1'b0, 2'd1, 2, 8, "R4 on-time code 3");
    run_cfg(1, 1, 8, 1'b1, 2'd3, 0, 4, "R5 half-phase on-time");
    run_cfg(7, 0, 9, 1'b0, 2'd0, 0, 2, "R5 full-phase on-time");
    run_cfg(0, 2, 12, 1'b0, 2'd2, 0, 3, "R6 unused code 12 off");
    run_cfg(0, 1, 0, 1'b1, 2'd1, 0, 2, "R6 code 0 off");
    run_cfg(1, 3, 7, 1'b1, 2'd2, 4, 8, "R4 on-time code 7");
    run_cfg(3, 2, 1, 1'b0, 2'd3, 3, 6, "R4 on-time code 1");
    run_cfg(0, 0, 9, 1'b0, 2'd1, 1, 3, "R5 full-phase single common");
    mon_on = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule